// File: doc/BRIEF.md
# Text-Mode VGA Character Generator

This block turns a byte-per-character screen buffer into a VGA raster. The timing is 800x600 at 60 Hz, produced at half the dot clock. With a 20 MHz pixel clock each line carries 400 visible pixels, which form 50 character cells of 8 pixels each. Each screen byte selects one of 128 stored glyphs. Bit 7 of the byte asks for the bitwise inverse of that glyph, so the upper half of the character set needs no font storage of its own.

Three synchronous read ports, each with one clock of latency, fetch the data. The screen port supplies character codes. The font port supplies glyph rows. The colour port supplies one foreground/background pair per scan line. The pair for a line and the glyph row for its first cell are both fetched in the horizontal back porch, so the pixel pipeline is already primed when the visible region opens.

Two configuration inputs set the glyph height and the number of times each glyph row is repeated. Their product times the number of text rows covers the 600 visible lines, so one design serves every text height from 75 rows down to 5 rows. The configuration is expected to stay constant outside reset.

Top module: `vga_text_gen`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP pixel clocks, which is 400+20+64+44=528 by default. The visible pixels come first. `hsync_n` is low for exactly H_SYNC clocks, starting H_ACTIVE+H_FP clocks after the line starts. Every output passes through one register stage.
- R2: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines, which is 600+1+4+23=628 by default. `vsync_n` is low for V_SYNC lines, starting at line V_ACTIVE+V_FP. It changes only at line boundaries.
- R3: `hsync_n` and `vsync_n` are both high whenever a visible pixel is output.
- R4: Outside the visible window, `red`, `grn` and `blu` are all zero.
- R5: Cell c of text row r shows the screen byte at address r*COLS+c, where COLS=H_ACTIVE/8. Glyph bit 7 is the leftmost pixel.
- R6: The font address is {code[6:0], glyph row}. When code bit 7 is 1, the 8 glyph bits are inverted before display.
- R7: `cfg_fh_m1` holds the glyph height minus one, and `cfg_rep_m1` holds the repeat count minus one. Visible line L shows glyph row (L / rep) mod fh of text row L / (rep*fh).
- R8: `clr_addr` carries the visible line index. `clr_data[11:6]` is the foreground and `clr_data[5:0]` is the background, each packed as {r[1:0],g[1:0],b[1:0]}. A glyph bit of 1 selects the foreground and a bit of 0 selects the background.
- R9: The first cell of every visible line shows its correct glyph and colours, with no stale pixels at the left edge.
- R10: During reset, `hsync_n` and `vsync_n` are 1 and the RGB outputs are 0. The internal reset is released two clocks after `rst_n` rises. The block then runs one blank line, the last line of the vertical back porch, before visible line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fh_m1 | input | FH_W | Glyph height minus one |
| cfg_rep_m1 | input | REP_W | Glyph-row repeat count minus one |
| scr_addr | output | SCR_AW | Screen buffer read address |
| scr_data | input | 8 | Character code, one clock after address |
| font_addr | output | 7+FH_W | Font read address {code[6:0], glyph row} |
| font_data | input | 8 | Glyph row bits, one clock after address |
| clr_addr | output | LINE_W | Colour-pair read address (line index) |
| clr_data | input | 12 | {fg, bg} colour pair, one clock after address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 2 | Red level |
| grn | output | 2 | Green level |
| blu | output | 2 | Blue level |

## Verification
Several properties are checked on every clock: the width of the hsync pulse, the period between hsync pulses, that vsync moves only at a line boundary, that syncs stay high whenever colour is shown, that RGB is blank past the visible columns, and that the glyph row stays within the configured height. Other behaviour only shows up in the pixel contents, so the bench scenarios must cover it. That includes the mapping from screen address to column, the inversion of upper codes, repetition of glyph rows, selection between the colour pair, the primed first cell, and the blank line after reset. Those scenarios compare every output cycle of whole frames under several height and repeat settings.

// File: rtl/vga_text_pkg.sv
package vga_text_pkg;
  localparam int CELL_W  = 8;
  localparam int CELL_B  = 3;
  localparam int CHAN_W  = 2;
  localparam int COLOR_W = 3 * CHAN_W;
  typedef logic [COLOR_W-1:0] color_t;
  typedef struct packed {
    color_t fg;
    color_t bg;
  } color_pair_t;
endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
  parameter int H_ACTIVE = 400,
  parameter int H_FP     = 20,
  parameter int H_SYNC   = 64,
  parameter int H_BP     = 44,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BP     = 23,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HC_W    = $clog2(H_TOTAL),
  localparam int LINE_W  = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [HC_W-1:0]   hcnt,
  output logic [LINE_W-1:0] nline,
  output logic              nline_vis,
  output logic              vis,
  output logic              hs_on,
  output logic              vs_on,
  output logic              line_last,
  output logic              prime
);
  logic [LINE_W-1:0] vcnt;
  logic [HC_W-1:0]   hcnt_d;
  logic [LINE_W-1:0] vcnt_d;

  always_comb begin
    line_last = (hcnt == HC_W'(H_TOTAL - 1));
    prime     = (hcnt == HC_W'(H_TOTAL - vga_text_pkg::CELL_W - 1));
    hcnt_d    = line_last ? '0 : hcnt + 1'b1;
    nline     = (vcnt == LINE_W'(V_TOTAL - 1)) ? '0 : vcnt + 1'b1;
    vcnt_d    = line_last ? nline : vcnt;
    nline_vis = (nline < LINE_W'(V_ACTIVE));
    vis       = (hcnt < HC_W'(H_ACTIVE)) && (vcnt < LINE_W'(V_ACTIVE));
    hs_on     = (hcnt >= HC_W'(H_ACTIVE + H_FP)) &&
                (hcnt <  HC_W'(H_ACTIVE + H_FP + H_SYNC));
    vs_on     = (vcnt >= LINE_W'(V_ACTIVE + V_FP)) &&
                (vcnt <  LINE_W'(V_ACTIVE + V_FP + V_SYNC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= LINE_W'(V_TOTAL - 1);
    end else begin
      hcnt <= hcnt_d;
      vcnt <= vcnt_d;
    end
  end
endmodule

// File: rtl/vga_row_track.sv
module vga_row_track #(
  parameter int COLS   = 50,
  parameter int FH_W   = 4,
  parameter int REP_W  = 4,
  parameter int SCR_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic              nline_vis,
  input  logic [FH_W-1:0]   cfg_fh_m1,
  input  logic [REP_W-1:0]  cfg_rep_m1,
  output logic [FH_W-1:0]   grow,
  output logic [SCR_AW-1:0] rowbase,
  output logic              row_vis
);
  logic [REP_W-1:0]  rep, rep_d;
  logic [FH_W-1:0]   grow_d;
  logic [SCR_AW-1:0] rowbase_d;
  logic              row_vis_d;

  always_comb begin
    rep_d     = rep;
    grow_d    = grow;
    rowbase_d = rowbase;
    row_vis_d = row_vis;
    if (step) begin
      row_vis_d = nline_vis;
      if (restart) begin
        rep_d     = '0;
        grow_d    = '0;
        rowbase_d = '0;
      end else if (nline_vis) begin
        if (rep == cfg_rep_m1) begin
          rep_d = '0;
          if (grow == cfg_fh_m1) begin
            grow_d    = '0;
            rowbase_d = rowbase + SCR_AW'(COLS);
          end else begin
            grow_d = grow + 1'b1;
          end
        end else begin
          rep_d = rep + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep     <= '0;
      grow    <= '0;
      rowbase <= '0;
      row_vis <= 1'b0;
    end else begin
      rep     <= rep_d;
      grow    <= grow_d;
      rowbase <= rowbase_d;
      row_vis <= row_vis_d;
    end
  end
endmodule

// File: rtl/vga_pixel_pipe.sv
module vga_pixel_pipe
  import vga_text_pkg::*;
#(
  parameter int COLS   = 50,
  parameter int FH_W   = 4,
  parameter int SCR_AW = 12,
  parameter int FCOL_W = 7,
  localparam int FONT_AW = 7 + FH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CELL_B-1:0]  ph,
  input  logic               prime,
  input  logic               line_last,
  input  logic               vis,
  input  logic               hs_on,
  input  logic               vs_on,
  input  logic               row_vis,
  input  logic [SCR_AW-1:0]  rowbase,
  input  logic [FH_W-1:0]    grow,
  input  logic [7:0]         scr_data,
  input  logic [7:0]         font_data,
  input  color_pair_t        clr_pair,
  output logic [SCR_AW-1:0]  scr_addr,
  output logic [FONT_AW-1:0] font_addr,
  output logic               hsync_n,
  output logic               vsync_n,
  output color_t             rgb
);
  logic [FCOL_W-1:0] fcol, fcol_d;
  logic              code_inv, code_inv_d;
  logic              cell_ok, cell_ok_d;
  logic [7:0]        glyph_nx, glyph_nx_d;
  logic [7:0]        sr, sr_d;
  color_pair_t       pair, pair_d;
  color_t            rgb_d;
  logic              hs_n_d, vs_n_d;
  logic              ph_code, ph_glyph, ph_load;

  always_comb begin
    ph_code  = (ph == CELL_B'(1));
    ph_glyph = (ph == CELL_B'(2));
    ph_load  = (ph == CELL_B'(CELL_W - 1));
    scr_addr  = rowbase + SCR_AW'(fcol);
    font_addr = {scr_data[6:0], grow};

    fcol_d     = prime ? '0 : (ph_load ? fcol + 1'b1 : fcol);
    code_inv_d = ph_code ? scr_data[7] : code_inv;
    cell_ok_d  = ph_code ? (row_vis && (fcol < FCOL_W'(COLS))) : cell_ok;
    glyph_nx_d = glyph_nx;
    if (ph_glyph) glyph_nx_d = cell_ok ? (font_data ^ {8{code_inv}}) : 8'h00;
    sr_d   = ph_load ? glyph_nx : {sr[6:0], 1'b0};
    pair_d = line_last ? (row_vis ? clr_pair : '0) : pair;

    rgb_d  = vis ? (sr[7] ? pair.fg : pair.bg) : '0;
    hs_n_d = ~hs_on | vis;
    vs_n_d = ~vs_on | vis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcol     <= '0;
      code_inv <= 1'b0;
      cell_ok  <= 1'b0;
      glyph_nx <= '0;
      sr       <= '0;
      pair     <= '0;
      rgb      <= '0;
      hsync_n  <= 1'b1;
      vsync_n  <= 1'b1;
    end else begin
      fcol     <= fcol_d;
      code_inv <= code_inv_d;
      cell_ok  <= cell_ok_d;
      glyph_nx <= glyph_nx_d;
      sr       <= sr_d;
      pair     <= pair_d;
      rgb      <= rgb_d;
      hsync_n  <= hs_n_d;
      vsync_n  <= vs_n_d;
    end
  end
endmodule

// File: rtl/vga_text_gen.sv
module vga_text_gen
  import vga_text_pkg::*;
#(
  parameter int H_ACTIVE = 400,
  parameter int H_FP     = 20,
  parameter int H_SYNC   = 64,
  parameter int H_BP     = 44,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BP     = 23,
  parameter int FH_W     = 4,
  parameter int REP_W    = 4,
  parameter int SCR_AW   = 12,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HC_W    = $clog2(H_TOTAL),
  localparam int LINE_W  = $clog2(V_TOTAL),
  localparam int COLS    = H_ACTIVE / CELL_W,
  localparam int FCOL_W  = $clog2(H_TOTAL / CELL_W + 1),
  localparam int FONT_AW = 7 + FH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FH_W-1:0]    cfg_fh_m1,
  input  logic [REP_W-1:0]   cfg_rep_m1,
  output logic [SCR_AW-1:0]  scr_addr,
  input  logic [7:0]         scr_data,
  output logic [FONT_AW-1:0] font_addr,
  input  logic [7:0]         font_data,
  output logic [LINE_W-1:0]  clr_addr,
  input  logic [11:0]        clr_data,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic [1:0]         red,
  output logic [1:0]         grn,
  output logic [1:0]         blu
);
  logic              rs_meta, rs_n;
  logic [HC_W-1:0]   h_cnt;
  logic [LINE_W-1:0] nline;
  logic              nline_vis, vis, hs_on, vs_on, line_last, prime;
  logic [FH_W-1:0]   grow;
  logic [SCR_AW-1:0] rowbase;
  logic              row_vis;
  color_t            rgb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  vga_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rs_n), .hcnt(h_cnt), .nline(nline),
    .nline_vis(nline_vis), .vis(vis), .hs_on(hs_on), .vs_on(vs_on),
    .line_last(line_last), .prime(prime)
  );

  vga_row_track #(
    .COLS(COLS), .FH_W(FH_W), .REP_W(REP_W), .SCR_AW(SCR_AW)
  ) u_rows (
    .clk(clk), .rst_n(rs_n), .step(prime), .restart(nline == '0),
    .nline_vis(nline_vis), .cfg_fh_m1(cfg_fh_m1), .cfg_rep_m1(cfg_rep_m1),
    .grow(grow), .rowbase(rowbase), .row_vis(row_vis)
  );

  vga_pixel_pipe #(
    .COLS(COLS), .FH_W(FH_W), .SCR_AW(SCR_AW), .FCOL_W(FCOL_W)
  ) u_pipe (
    .clk(clk), .rst_n(rs_n), .ph(h_cnt[CELL_B-1:0]), .prime(prime),
    .line_last(line_last), .vis(vis), .hs_on(hs_on), .vs_on(vs_on),
    .row_vis(row_vis), .rowbase(rowbase), .grow(grow),
    .scr_data(scr_data), .font_data(font_data),
    .clr_pair(color_pair_t'(clr_data)),
    .scr_addr(scr_addr), .font_addr(font_addr),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
  );

  assign clr_addr = nline;
  assign red = rgb[5:4];
  assign grn = rgb[3:2];
  assign blu = rgb[1:0];
endmodule

// File: rtl/vga_text_gen_chk.sv
module vga_text_gen_chk #(
  parameter int H_ACTIVE = 400,
  parameter int H_FP     = 20,
  parameter int H_SYNC   = 64,
  parameter int H_BP     = 44,
  parameter int FH_W     = 4,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int HC_W    = $clog2(H_TOTAL)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic [1:0]        red,
  input logic [1:0]        grn,
  input logic [1:0]        blu,
  input logic [HC_W-1:0]   h_cnt,
  input logic [FH_W-1:0]   glyph_row,
  input logic [FH_W-1:0]   cfg_fh_m1
);
  logic [15:0] lo_cnt, per_cnt;
  logic        hs_q, seen;
  logic        hs_fall;

  assign hs_fall = hs_q & ~hsync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt  <= '0;
      per_cnt <= '0;
      hs_q    <= 1'b1;
      seen    <= 1'b0;
    end else begin
      lo_cnt  <= hsync_n ? 16'd0 : lo_cnt + 16'd1;
      per_cnt <= hs_fall ? 16'd1 : per_cnt + 16'd1;
      hs_q    <= hsync_n;
      if (hs_fall) seen <= 1'b1;
    end
  end

  assert_hsync_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> (lo_cnt == 16'(H_SYNC)));

  assert_line_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fall && seen) |-> (per_cnt == 16'(H_TOTAL)));

  assert_vsync_at_line_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_n) |-> (h_cnt == HC_W'(1)));

  assert_sync_high_with_colour_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({red, grn, blu} != 6'd0) |-> (hsync_n && vsync_n));

  assert_blank_past_columns_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(h_cnt) >= HC_W'(H_ACTIVE)) |-> ({red, grn, blu} == 6'd0));

  assert_blank_in_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> ({red, grn, blu} == 6'd0));

  assert_glyph_row_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    glyph_row <= cfg_fh_m1);
endmodule

bind vga_text_gen vga_text_gen_chk #(
  .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .FH_W(FH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .red(red), .grn(grn), .blu(blu), .h_cnt(h_cnt),
  .glyph_row(font_addr[FH_W-1:0]), .cfg_fh_m1(cfg_fh_m1)
);

// File: tb/tb_vga_text_gen.sv
module tb_vga_text_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 32, HF = 8, HS = 8, HB = 16;
  localparam int VA = 12, VF = 1, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int COLS = HA / 8;
  localparam int FH_W = 4, REP_W = 4, SCR_AW = 12;
  localparam int LINE_W = $clog2(VT);

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              rst_n;
  logic [FH_W-1:0]   cfg_fh_m1;
  logic [REP_W-1:0]  cfg_rep_m1;
  logic [SCR_AW-1:0] scr_addr;
  logic [7:0]        scr_data;
  logic [10:0]       font_addr;
  logic [7:0]        font_data;
  logic [LINE_W-1:0] clr_addr;
  logic [11:0]       clr_data;
  logic              hsync_n, vsync_n;
  logic [1:0]        red, grn, blu;

  vga_text_gen #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .FH_W(FH_W), .REP_W(REP_W), .SCR_AW(SCR_AW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_fh_m1(cfg_fh_m1), .cfg_rep_m1(cfg_rep_m1),
    .scr_addr(scr_addr), .scr_data(scr_data),
    .font_addr(font_addr), .font_data(font_data),
    .clr_addr(clr_addr), .clr_data(clr_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .grn(grn), .blu(blu)
  );

  logic [7:0]  scr_mem  [0:4095];
  logic [7:0]  font_mem [0:2047];
  logic [11:0] clr_mem  [0:31];

  always @(posedge clk) begin
    scr_data  <= scr_mem[scr_addr];
    font_data <= font_mem[font_addr];
    clr_data  <= clr_mem[clr_addr];
  end

  typedef struct {
    logic       hs;
    logic       vs;
    logic [5:0] rgb;
    bit         act;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   bad = 0;
  bit   mon_on = 1'b0;
  int   mon_k = 0;

  function automatic exp_t model(int n, int fh, int rep);
    exp_t e;
    int h, ln, col, px, grw, crow, code;
    logic [7:0]  g;
    logic [11:0] cp;
    h  = n % HT;
    ln = (VT - 1 + n / HT) % VT;
    e.hs  = !(h >= HA + HF && h < HA + HF + HS);
    e.vs  = !(ln >= VA + VF && ln < VA + VF + VS);
    e.rgb = 6'd0;
    e.act = 1'b0;
    e.req = "R4";
    if (h < HA && ln < VA) begin
      e.act = 1'b1;
      col  = h / 8;
      px   = h % 8;
      grw  = (ln / rep) % fh;
      crow = ln / (rep * fh);
      code = int'(scr_mem[(crow * COLS + col) & 4095]);
      g    = font_mem[((code & 127) << FH_W) | grw];
      if (code >= 128) g = ~g;
      cp    = clr_mem[ln];
      e.rgb = g[7 - px] ? cp[11:6] : cp[5:0];
      if (col == 0)          e.req = "R9";
      else if (code >= 128)  e.req = "R6";
      else if (!g[7 - px])   e.req = "R8";
      else if (grw != 0)     e.req = "R7";
      else                   e.req = "R5";
    end
    return e;
  endfunction

  // Monitor: pops one expected item per output cycle and compares.
  always @(negedge clk) begin
    exp_t  e;
    string rq;
    if (mon_on) begin
      if (mon_k >= 3 && q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if ({red, grn, blu} !== e.rgb) begin
          bad++;
          $display("FAIL %s rgb actual=%h expected=%h", e.req, {red, grn, blu}, e.rgb);
        end else if (hsync_n !== e.hs) begin
          bad++;
          rq = e.act ? "R3" : "R1";
          $display("FAIL %s hsync_n actual=%b expected=%b", rq, hsync_n, e.hs);
        end else if (vsync_n !== e.vs) begin
          bad++;
          rq = e.act ? "R3" : "R2";
          $display("FAIL %s vsync_n actual=%b expected=%b", rq, vsync_n, e.vs);
        end
      end
      mon_k++;
    end
  end

  task automatic run_case(int fh_m1, int rep_m1, int seed, int frames);
    @(negedge clk);
    rst_n      = 1'b0;
    cfg_fh_m1  = FH_W'(fh_m1);
    cfg_rep_m1 = REP_W'(rep_m1);
    for (int i = 0; i < 4096; i++) scr_mem[i]  = 8'((i * 53 + seed * 17 + (i >> 2)) & 255);
    for (int i = 0; i < 2048; i++) font_mem[i] = 8'(((i * 97 + seed * 31) ^ (i >> 3)) & 255);
    for (int i = 0; i < 32; i++)   clr_mem[i]  = 12'((i * 211 + seed * 5 + 1) & 4095);
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    checks++;
    if (hsync_n !== 1'b1 || vsync_n !== 1'b1 || {red, grn, blu} !== 6'd0) begin
      bad++;
      $display("FAIL R10 reset outputs actual=%b%b%h expected=11%h",
               hsync_n, vsync_n, {red, grn, blu}, 6'd0);
    end
    // Driver: push the whole expected schedule
    for (int n = 0; n < frames * VT * HT; n++) q.push_back(model(n, fh_m1 + 1, rep_m1 + 1));
    rst_n = 1'b1;
    @(posedge clk);
    mon_k  = 1;
    mon_on = 1'b1;
    while (q.size() != 0) @(negedge clk);
    mon_on = 1'b0;
  endtask

  initial begin
    rst_n      = 1'b0;
    cfg_fh_m1  = '0;
    cfg_rep_m1 = '0;
    run_case(3, 0, 1, 2);   // 4-line glyphs, no repeat
    run_case(1, 2, 2, 1);   // 2-line glyphs, each row shown 3 times
    run_case(0, 0, 3, 1);   // 1-line glyphs
    run_case(15, 1, 4, 1);  // tallest glyphs, doubled rows
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule